// File: doc/BRIEF.md
# Superscalar Issue Port Allocator

This block sits at the issue stage of an in-order superscalar core. Every cycle it looks at up to `NSLOT` decoded instructions, held oldest first in slot 0 upward, and assigns each one to execution ports. There are six ports: two load/store pipes, two integer pipes and two floating-point pipes. The integer and floating-point pipes share two issue lanes, so an integer pipe and its floating-point partner cannot both be used in one cycle. Each slot brings a valid bit, a 4-bit class code and an operand-ready flag. The block reports, for each slot, either a grant with the chosen port (plus a second port for stores) or a stall. Program order is kept: when a slot stalls, no younger slot may issue in that cycle.

Ports are searched in a fixed order of preference. Some classes may use only one port. Stores need a load/store port and an execute port in the same cycle. Two mode inputs, one for floating-point exceptions and one for 32-bit floating-point operation, each confine floating-point execute work to a single pipe. Decisions are taken from the current inputs and are held in an output register, so they appear one clock after the inputs. The block does no decode, tracks no operand latency and holds no execution pipes.

Top module: `iss_port_alloc`

## Requirements
- R1: While `rst_n` is low, every grant, stall, port index and second-port valid output is zero.
- R2: The decision for the inputs present at a rising clock edge appears on the outputs just after that edge and is held until the next edge. Port index codes are: 0 load/store pipe A, 1 load/store pipe B, 2 integer pipe A, 3 integer pipe B, 4 FP pipe A, 5 FP pipe B. Integer pipe A and FP pipe A share a lane. Integer pipe B and FP pipe B share the other lane.
- R3: A valid slot is granted only if every older valid slot was granted in the same cycle. A valid slot that is not granted raises its stall and blocks all younger slots. An invalid slot raises neither output and blocks nothing.
- R4: No port and no shared lane is given to two slots in one cycle.
- R5: Class 2 (shift, conditional move) takes integer pipe B if that lane is free, otherwise integer pipe A.
- R6: Class 5 (plain load or prefetch) takes load/store pipe A, then pipe B. Class 6 (indexed load or indexed prefetch) may use only load/store pipe B.
- R7: Class 1 (constant, add, logical, move, sign-extend) takes load/store pipe B when that pipe is free and the slot's ready flag is 1. Otherwise it takes integer pipe B, then integer pipe A.
- R8: Class 3 (set-less-than, leading-zero count, trap, branch, jump, call) may use only integer pipe A. Class 4 (multiply, hi/lo moves, divide) may use only integer pipe B.
- R9: Class 7 (store) is granted only with both a load/store port (A before B) and an integer port (B before A). Class 8 (FP store) needs a load/store port (A before B) and an FP port (B before A). Class 9 (indexed FP store) needs load/store pipe B and an FP port (B before A). The load/store port is reported as the primary port and the other port as the second port.
- R10: Class 10 (FP execute) takes FP pipe B, then FP pipe A. When `i_fpexc_en` or `i_fp32_mode` is 1, it may use only FP pipe B. Class 11 may use only FP pipe B, and class 12 (register transfer) only FP pipe A.
- R11: Classes 0, 13, 14 and 15 (unknown or multi) claim all six ports. Such a slot is granted only when no older slot was granted, reports primary port 0 with no second port, and stalls every younger valid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_fpexc_en | input | 1 | FP exceptions enabled, restricts FP execute to one pipe |
| i_fp32_mode | input | 1 | 32-bit FP mode, restricts FP execute to one pipe |
| i_vld | input | NSLOT | Slot holds an instruction |
| i_cls | input | NSLOT x 4 | Class code per slot |
| i_rdy | input | NSLOT | Operands ready for the load/store-pipe ALU path |
| o_grant | output | NSLOT | Slot issued |
| o_stall | output | NSLOT | Valid slot held back |
| o_port | output | NSLOT x 3 | Primary port index of a granted slot |
| o_aux_vld | output | NSLOT | Granted slot also holds a second port |
| o_aux_port | output | NSLOT x 3 | Second port index (execute side of a store) |

## Verification
The bench builds the allocator with its default of four slots. That is the widest issue group the port set can fill, so every port can be taken at once and the fourth slot can be starved. This lets the tests reach both lanes taken by floating-point work while a simple ALU operation falls back to load/store pipe B, a store that finds a load/store port but no execute lane, and a multi-class operation placed behind a granted slot. Random class mixes with random valid and ready bits cover the two restricted floating-point modes and holes in the slot group.

// File: rtl/iss_pkg.sv
package iss_pkg;

    localparam int CLS_W  = 4;
    localparam int PORT_W = 3;
    localparam int NRES   = 4;

    // resource bits: two load/store pipes, two shared execute lanes
    localparam int RS_LS0 = 0;
    localparam int RS_LS1 = 1;
    localparam int RS_LNA = 2;   // integer A / FP A
    localparam int RS_LNB = 3;   // integer B / FP B

    localparam logic [PORT_W-1:0] PT_LS0 = 3'd0;
    localparam logic [PORT_W-1:0] PT_LS1 = 3'd1;
    localparam logic [PORT_W-1:0] PT_EX0 = 3'd2;
    localparam logic [PORT_W-1:0] PT_EX1 = 3'd3;
    localparam logic [PORT_W-1:0] PT_FP0 = 3'd4;
    localparam logic [PORT_W-1:0] PT_FP1 = 3'd5;

    localparam logic [CLS_W-1:0] CL_MULTI = 4'd0;
    localparam logic [CLS_W-1:0] CL_SALU  = 4'd1;
    localparam logic [CLS_W-1:0] CL_ALU   = 4'd2;
    localparam logic [CLS_W-1:0] CL_EXA   = 4'd3;
    localparam logic [CLS_W-1:0] CL_EXB   = 4'd4;
    localparam logic [CLS_W-1:0] CL_LD    = 4'd5;
    localparam logic [CLS_W-1:0] CL_LDX   = 4'd6;
    localparam logic [CLS_W-1:0] CL_ST    = 4'd7;
    localparam logic [CLS_W-1:0] CL_FST   = 4'd8;
    localparam logic [CLS_W-1:0] CL_FSTX  = 4'd9;
    localparam logic [CLS_W-1:0] CL_FEXE  = 4'd10;
    localparam logic [CLS_W-1:0] CL_FPB   = 4'd11;
    localparam logic [CLS_W-1:0] CL_FPA   = 4'd12;

    typedef enum logic [1:0] {
        LK_NONE,     // no load/store pipe
        LK_ANY,      // pipe A then pipe B
        LK_ONLYB,    // pipe B only
        LK_OPTB      // pipe B if free and ready, else execute side
    } ls_kind_e;

    typedef enum logic [3:0] {
        XK_NONE,
        XK_INT_ANY,
        XK_INT_A,
        XK_INT_B,
        XK_FP_ANY,
        XK_FP_EXE,
        XK_FP_A,
        XK_FP_B,
        XK_ALL
    } ex_kind_e;

    typedef struct packed {
        ls_kind_e ls;
        ex_kind_e ex;
    } need_t;

endpackage

// File: rtl/iss_class_decode.sv
module iss_class_decode
    import iss_pkg::*;
(
    input  logic [CLS_W-1:0] i_cls,
    output need_t            o_need
);

    always_comb begin
        o_need = '{ls: LK_NONE, ex: XK_ALL};
        unique case (i_cls)
            CL_SALU: o_need = '{ls: LK_OPTB,  ex: XK_INT_ANY};
            CL_ALU:  o_need = '{ls: LK_NONE,  ex: XK_INT_ANY};
            CL_EXA:  o_need = '{ls: LK_NONE,  ex: XK_INT_A};
            CL_EXB:  o_need = '{ls: LK_NONE,  ex: XK_INT_B};
            CL_LD:   o_need = '{ls: LK_ANY,   ex: XK_NONE};
            CL_LDX:  o_need = '{ls: LK_ONLYB, ex: XK_NONE};
            CL_ST:   o_need = '{ls: LK_ANY,   ex: XK_INT_ANY};
            CL_FST:  o_need = '{ls: LK_ANY,   ex: XK_FP_ANY};
            CL_FSTX: o_need = '{ls: LK_ONLYB, ex: XK_FP_ANY};
            CL_FEXE: o_need = '{ls: LK_NONE,  ex: XK_FP_EXE};
            CL_FPB:  o_need = '{ls: LK_NONE,  ex: XK_FP_B};
            CL_FPA:  o_need = '{ls: LK_NONE,  ex: XK_FP_A};
            default: o_need = '{ls: LK_NONE,  ex: XK_ALL};
        endcase
    end

endmodule

// File: rtl/iss_slot_pick.sv
module iss_slot_pick
    import iss_pkg::*;
(
    input  need_t             i_need,
    input  logic [NRES-1:0]   i_free,
    input  logic              i_rdy,
    input  logic              i_one_fp,
    output logic              o_ok,
    output logic [NRES-1:0]   o_take,
    output logic [PORT_W-1:0] o_pri,
    output logic              o_aux_vld,
    output logic [PORT_W-1:0] o_aux
);

    logic              alu_on_ls;
    logic              ls_ok, ex_ok;
    logic [NRES-1:0]   ls_take, ex_take;
    logic [PORT_W-1:0] ls_port, ex_port;
    ex_kind_e          ex_eff;

    assign alu_on_ls = (i_need.ls == LK_OPTB) && i_free[RS_LS1] && i_rdy;
    assign ex_eff    = alu_on_ls ? XK_NONE : i_need.ex;

    // load/store side
    always_comb begin
        ls_ok   = 1'b1;
        ls_take = '0;
        ls_port = PT_LS0;
        unique case (i_need.ls)
            LK_ANY: begin
                if (i_free[RS_LS0]) begin
                    ls_take[RS_LS0] = 1'b1;
                end else if (i_free[RS_LS1]) begin
                    ls_take[RS_LS1] = 1'b1;
                    ls_port         = PT_LS1;
                end else begin
                    ls_ok = 1'b0;
                end
            end
            LK_ONLYB: begin
                ls_ok           = i_free[RS_LS1];
                ls_take[RS_LS1] = 1'b1;
                ls_port         = PT_LS1;
            end
            LK_OPTB: begin
                if (alu_on_ls) begin
                    ls_take[RS_LS1] = 1'b1;
                    ls_port         = PT_LS1;
                end
            end
            default: ;
        endcase
    end

    // execute side: lane B is searched before lane A
    always_comb begin
        ex_ok   = 1'b1;
        ex_take = '0;
        ex_port = PT_EX1;
        unique case (ex_eff)
            XK_INT_ANY: begin
                if (i_free[RS_LNB]) begin
                    ex_take[RS_LNB] = 1'b1;
                end else if (i_free[RS_LNA]) begin
                    ex_take[RS_LNA] = 1'b1;
                    ex_port         = PT_EX0;
                end else begin
                    ex_ok = 1'b0;
                end
            end
            XK_INT_A: begin
                ex_ok           = i_free[RS_LNA];
                ex_take[RS_LNA] = 1'b1;
                ex_port         = PT_EX0;
            end
            XK_INT_B: begin
                ex_ok           = i_free[RS_LNB];
                ex_take[RS_LNB] = 1'b1;
            end
            XK_FP_ANY, XK_FP_EXE: begin
                if (i_free[RS_LNB]) begin
                    ex_take[RS_LNB] = 1'b1;
                    ex_port         = PT_FP1;
                end else if (i_free[RS_LNA] &&
                             !(ex_eff == XK_FP_EXE && i_one_fp)) begin
                    ex_take[RS_LNA] = 1'b1;
                    ex_port         = PT_FP0;
                end else begin
                    ex_ok = 1'b0;
                end
            end
            XK_FP_A: begin
                ex_ok           = i_free[RS_LNA];
                ex_take[RS_LNA] = 1'b1;
                ex_port         = PT_FP0;
            end
            XK_FP_B: begin
                ex_ok           = i_free[RS_LNB];
                ex_take[RS_LNB] = 1'b1;
                ex_port         = PT_FP1;
            end
            XK_ALL: begin
                ex_ok   = &i_free;
                ex_take = '1;
            end
            default: ;
        endcase
    end

    always_comb begin
        o_ok      = ls_ok && ex_ok;
        o_take    = ls_take | ex_take;
        o_aux_vld = 1'b0;
        o_aux     = '0;
        if (ex_eff == XK_ALL) begin
            o_pri = PT_LS0;
        end else if (i_need.ls == LK_ANY || i_need.ls == LK_ONLYB || alu_on_ls) begin
            o_pri = ls_port;
            if (ex_eff != XK_NONE) begin
                o_aux_vld = 1'b1;
                o_aux     = ex_port;
            end
        end else begin
            o_pri = ex_port;
        end
    end

endmodule

// File: rtl/iss_port_alloc.sv
module iss_port_alloc
    import iss_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         i_fpexc_en,
    input  logic                         i_fp32_mode,
    input  logic [NSLOT-1:0]             i_vld,
    input  logic [NSLOT-1:0][CLS_W-1:0]  i_cls,
    input  logic [NSLOT-1:0]             i_rdy,
    output logic [NSLOT-1:0]             o_grant,
    output logic [NSLOT-1:0]             o_stall,
    output logic [NSLOT-1:0][PORT_W-1:0] o_port,
    output logic [NSLOT-1:0]             o_aux_vld,
    output logic [NSLOT-1:0][PORT_W-1:0] o_aux_port
);

    logic                 one_fp;
    logic [NRES-1:0]      free_c [NSLOT+1];
    logic                 blk_c  [NSLOT+1];
    logic [NSLOT-1:0]     go;
    logic [NSLOT-1:0]     aux_c;
    logic [PORT_W-1:0]    pri_c  [NSLOT];
    logic [PORT_W-1:0]    auxp_c [NSLOT];

    assign one_fp    = i_fpexc_en | i_fp32_mode;
    assign free_c[0] = '1;
    assign blk_c[0]  = 1'b0;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        need_t           need;
        logic            ok;
        logic [NRES-1:0] take;

        iss_class_decode u_dec (
            .i_cls  (i_cls[s]),
            .o_need (need)
        );

        iss_slot_pick u_pick (
            .i_need    (need),
            .i_free    (free_c[s]),
            .i_rdy     (i_rdy[s]),
            .i_one_fp  (one_fp),
            .o_ok      (ok),
            .o_take    (take),
            .o_pri     (pri_c[s]),
            .o_aux_vld (aux_c[s]),
            .o_aux     (auxp_c[s])
        );

        assign go[s]       = i_vld[s] && !blk_c[s] && ok;
        assign free_c[s+1] = go[s] ? (free_c[s] & ~take) : free_c[s];
        assign blk_c[s+1]  = blk_c[s] | (i_vld[s] & ~go[s]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_grant    <= '0;
            o_stall    <= '0;
            o_port     <= '0;
            o_aux_vld  <= '0;
            o_aux_port <= '0;
        end else begin
            o_grant   <= go;
            o_stall   <= i_vld & ~go;
            o_aux_vld <= go & aux_c;
            for (int s = 0; s < NSLOT; s++) begin
                o_port[s]     <= go[s] ? pri_c[s] : '0;
                o_aux_port[s] <= (go[s] && aux_c[s]) ? auxp_c[s] : '0;
            end
        end
    end

endmodule

// File: rtl/iss_port_alloc_chk.sv
module iss_port_alloc_chk
    import iss_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         i_fpexc_en,
    input logic                         i_fp32_mode,
    input logic [NSLOT-1:0][CLS_W-1:0]  i_cls,
    input logic [NSLOT-1:0]             o_grant,
    input logic [NSLOT-1:0]             o_stall,
    input logic [NSLOT-1:0][PORT_W-1:0] o_port,
    input logic [NSLOT-1:0]             o_aux_vld,
    input logic [NSLOT-1:0][PORT_W-1:0] o_aux_port
);

    logic [NSLOT-1:0][CLS_W-1:0] cls_q;
    logic                        onefp_q;

    always_ff @(posedge clk) begin
        cls_q   <= i_cls;
        onefp_q <= i_fpexc_en | i_fp32_mode;
    end

    function automatic logic [NRES-1:0] res_of(input logic [PORT_W-1:0] p);
        unique case (p)
            PT_LS0:         res_of = 4'b0001;
            PT_LS1:         res_of = 4'b0010;
            PT_EX0, PT_FP0: res_of = 4'b0100;
            default:        res_of = 4'b1000;
        endcase
    endfunction

    logic [NRES-1:0] used [NSLOT];
    for (genvar s = 0; s < NSLOT; s++) begin : g_use
        logic multi;
        assign multi   = (cls_q[s] == CL_MULTI) || (cls_q[s] > CL_FPA);
        assign used[s] = !o_grant[s] ? '0 :
                         multi ? '1 :
                         res_of(o_port[s]) | (o_aux_vld[s] ? res_of(o_aux_port[s]) : '0);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (o_grant == '0 && o_stall == '0 && o_aux_vld == '0);
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_one
        assert_grant_or_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(o_grant[i] && o_stall[i]));

        assert_pin_inta_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (o_grant[i] && cls_q[i] == CL_EXA) |-> o_port[i] == PT_EX0);

        assert_pin_intb_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (o_grant[i] && cls_q[i] == CL_EXB) |-> o_port[i] == PT_EX1);

        assert_idx_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (o_grant[i] && cls_q[i] == CL_LDX) |-> o_port[i] == PT_LS1);

        assert_one_fp_pipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (o_grant[i] && cls_q[i] == CL_FEXE && onefp_q) |-> o_port[i] == PT_FP1);

        assert_multi_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (o_grant[i] && (cls_q[i] == CL_MULTI || cls_q[i] > CL_FPA))
                |-> $countones(o_grant) == 1);

        for (genvar j = i + 1; j < NSLOT; j++) begin : g_pair
            assert_in_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
                o_stall[i] |-> !o_grant[j]);

            assert_no_share_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (used[i] & used[j]) == '0);
        end
    end

endmodule

bind iss_port_alloc iss_port_alloc_chk #(.NSLOT(NSLOT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .i_fpexc_en (i_fpexc_en),
    .i_fp32_mode(i_fp32_mode),
    .i_cls      (i_cls),
    .o_grant    (o_grant),
    .o_stall    (o_stall),
    .o_port     (o_port),
    .o_aux_vld  (o_aux_vld),
    .o_aux_port (o_aux_port)
);

// File: tb/iss_port_alloc_tb.sv
module iss_port_alloc_tb_top;

    localparam int NS = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                fpexc = 1'b0;
    logic                fp32 = 1'b0;
    logic [NS-1:0]       vld = '0;
    logic [NS-1:0][3:0]  cls = '0;
    logic [NS-1:0]       rdy = '0;
    logic [NS-1:0]       o_grant, o_stall, o_aux_vld;
    logic [NS-1:0][2:0]  o_port, o_aux_port;

    logic [NS-1:0]       eg, es, eav;
    int                  ep [NS];
    int                  ea [NS];
    int                  n_chk = 0;
    int                  n_bad = 0;
    bit                  done = 0;

    always #2.5 clk = ~clk;

    iss_port_alloc #(.NSLOT(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .i_fpexc_en(fpexc), .i_fp32_mode(fp32),
        .i_vld(vld), .i_cls(cls), .i_rdy(rdy),
        .o_grant(o_grant), .o_stall(o_stall), .o_port(o_port),
        .o_aux_vld(o_aux_vld), .o_aux_port(o_aux_port)
    );

    // used: bit n set when port n (0..5) is taken
    function automatic bit pfree(logic [5:0] u, int p);
        if (p < 0) return 0;
        if (p == 2 || p == 4) return !u[2] && !u[4];
        if (p == 3 || p == 5) return !u[3] && !u[5];
        return !u[p];
    endfunction

    function automatic int first2(logic [5:0] u, int a, int b);
        if (pfree(u, a)) return a;
        if (pfree(u, b)) return b;
        return -1;
    endfunction

    function automatic string tag_of(logic [3:0] c);
        case (c)
            4'd1:             return "R7";
            4'd2:             return "R5";
            4'd3, 4'd4:       return "R8";
            4'd5, 4'd6:       return "R6";
            4'd7, 4'd8, 4'd9: return "R9";
            4'd10,4'd11,4'd12:return "R10";
            default:          return "R11";
        endcase
    endfunction

    task automatic model();
        logic [5:0] u = '0;
        bit blocked = 0;
        bit onefp = fpexc | fp32;
        for (int s = 0; s < NS; s++) begin
            int p = -1;
            int a = -1;
            bit ok = 0;
            eg[s] = 0; es[s] = 0; eav[s] = 0; ep[s] = 0; ea[s] = 0;
            if (vld[s]) begin
                case (cls[s])
                    4'd1: begin
                        if (pfree(u, 1) && rdy[s]) p = 1; else p = first2(u, 3, 2);
                        ok = p >= 0;
                    end
                    4'd2:  begin p = first2(u, 3, 2); ok = p >= 0; end
                    4'd3:  begin p = first2(u, 2, -1); ok = p >= 0; end
                    4'd4:  begin p = first2(u, 3, -1); ok = p >= 0; end
                    4'd5:  begin p = first2(u, 0, 1); ok = p >= 0; end
                    4'd6:  begin p = first2(u, 1, -1); ok = p >= 0; end
                    4'd7:  begin p = first2(u, 0, 1); a = first2(u, 3, 2); ok = p >= 0 && a >= 0; end
                    4'd8:  begin p = first2(u, 0, 1); a = first2(u, 5, 4); ok = p >= 0 && a >= 0; end
                    4'd9:  begin p = first2(u, 1, -1); a = first2(u, 5, 4); ok = p >= 0 && a >= 0; end
                    4'd10: begin p = first2(u, 5, onefp ? -1 : 4); ok = p >= 0; end
                    4'd11: begin p = first2(u, 5, -1); ok = p >= 0; end
                    4'd12: begin p = first2(u, 4, -1); ok = p >= 0; end
                    default: begin p = 0; ok = (u == '0); end
                endcase
                if (ok && !blocked) begin
                    eg[s] = 1; ep[s] = p;
                    if (a >= 0) begin eav[s] = 1; ea[s] = a; u[a] = 1'b1; end
                    if (cls[s] == 4'd0 || cls[s] > 4'd12) u = '1; else u[p] = 1'b1;
                end else begin
                    es[s] = 1; blocked = 1;
                end
            end
        end
    endtask

    task automatic chk(bit good, string req, string what, int act, int exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [5:0] seen = '0;
        bit clash = 0;
        for (int s = 0; s < NS; s++) begin
            string t = tag_of(cls[s]);
            chk(o_stall[s] === es[s], "R3", $sformatf("slot%0d stall", s), o_stall[s], es[s]);
            chk(o_grant[s] === eg[s], t, $sformatf("slot%0d grant", s), o_grant[s], eg[s]);
            if (eg[s] && o_grant[s]) begin
                chk(int'(o_port[s]) == ep[s], t, $sformatf("slot%0d port", s), o_port[s], ep[s]);
                chk(o_aux_vld[s] === eav[s], t, $sformatf("slot%0d aux valid", s), o_aux_vld[s], eav[s]);
                if (eav[s])
                    chk(int'(o_aux_port[s]) == ea[s], t, $sformatf("slot%0d aux port", s), o_aux_port[s], ea[s]);
                if (!(cls[s] == 4'd0 || cls[s] > 4'd12)) begin
                    if (seen[o_port[s]]) clash = 1;
                    seen[o_port[s]] = 1'b1;
                end
            end
        end
        chk(!clash, "R4", "port given twice", clash, 0);
    endtask

    // drive at the falling edge, check hold before the rising edge, check result after it
    task automatic step();
        logic [NS-1:0] prev_g;
        @(negedge clk);
        prev_g = o_grant;
        model();
        #1;
        chk(o_grant === prev_g, "R2", "outputs changed before edge", o_grant, prev_g);
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic put(logic [3:0] c0, logic [3:0] c1, logic [3:0] c2, logic [3:0] c3,
                       logic [NS-1:0] v, logic [NS-1:0] r);
        @(negedge clk);
        cls[0] = c0; cls[1] = c1; cls[2] = c2; cls[3] = c3;
        vld = v; rdy = r;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        vld = 4'hF; cls = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(o_grant === '0 && o_stall === '0 && o_aux_vld === '0, "R1", "reset outputs",
            {o_grant, o_stall}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R7: LS1 path, then lane B, lane A, then stall
        put(4'd1, 4'd1, 4'd1, 4'd1, 4'hF, 4'hF); step();
        // R7: not ready, skips LS1
        put(4'd1, 4'd1, 4'd1, 4'd5, 4'hF, 4'h0); step();
        // R6: loads A then B then stall; R3 younger blocked
        put(4'd5, 4'd5, 4'd5, 4'd2, 4'hF, 4'h0); step();
        // R6: indexed load behind indexed load stalls
        put(4'd6, 4'd6, 4'd2, 4'd2, 4'hF, 4'h0); step();
        // R9: two stores then ALU starved
        put(4'd7, 4'd7, 4'd2, 4'd5, 4'hF, 4'h0); step();
        put(4'd8, 4'd9, 4'd9, 4'd5, 4'hF, 4'h0); step();
        // R8: pinned classes competing
        put(4'd3, 4'd3, 4'd4, 4'd4, 4'hF, 4'h0); step();
        // R10: FP execute in both modes
        put(4'd10, 4'd10, 4'd5, 4'd5, 4'hF, 4'h0); step();
        fpexc = 1'b1; put(4'd10, 4'd10, 4'd5, 4'd5, 4'hF, 4'h0); step();
        fpexc = 1'b0; fp32 = 1'b1; put(4'd10, 4'd10, 4'd5, 4'd5, 4'hF, 4'h0); step();
        fp32 = 1'b0; put(4'd12, 4'd11, 4'd2, 4'd5, 4'hF, 4'h0); step();
        // R11: multi alone, and multi behind a grant
        put(4'd0, 4'd5, 4'd2, 4'd1, 4'hF, 4'hF); step();
        put(4'd2, 4'd14, 4'd5, 4'd5, 4'hF, 4'h0); step();
        put(4'd15, 4'd5, 4'd5, 4'd5, 4'h1, 4'h0); step();
        // R3: invalid slot does not block
        put(4'd0, 4'd5, 4'd0, 4'd2, 4'b1010, 4'h0); step();

        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            for (int s = 0; s < NS; s++) begin
                cls[s] = ($urandom % 16 == 0) ? 4'($urandom % 16) : 4'(1 + $urandom % 12);
                vld[s] = ($urandom % 8) != 0;
                rdy[s] = $urandom % 2;
            end
            fpexc = ($urandom % 4) == 0;
            fp32  = ($urandom % 4) == 0;
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule